// File: doc/BRIEF.md
# Three-State Cache Line Coherence Controller

This block tracks the coherence state of a small bank of cache lines inside one cache controller of a snooping shared-memory multiprocessor. Every line is Invalid, Shared or Owned and carries a dirty flag. Local processor loads and stores come in on a request port. Snooped bus messages come in on a second port: an invalidation, or a downgrade from owner to sharer. The block decides, line by line, whether a local access can complete at once. If it cannot, it raises a bus transaction and holds the access until the bus acknowledges it. Before it answers a snoop that would destroy modified data, it asks for a writeback.

A load or store that hits its line (any access to an Owned line, a load to a Shared line) finishes in the cycle it is presented, with no bus traffic. A load miss asks the bus to strip the current owner of its copy and installs the line as Shared. A store miss, or a store to a Shared line, asks the bus to invalidate every other copy and installs the line as Owned and dirty. Snoops always take precedence over local work. While a snoop is pending or its writeback is outstanding, no local access commits.

The data array, the memory model and the bus arbiter sit outside. They are seen only as request/acknowledge pairs.

Top module: `coh_line_ctrl`

## Requirements
- R1: After reset every line is Invalid and clean, and bus_req, wb_req, lreq_done and snp_ack are low.
- R2: A load to an Invalid line raises bus_req with bus_excl=0 (owner-only invalidation) and the line's index on bus_line. After bus_ack, lreq_done pulses in the following cycle and the line becomes Shared.
- R3: A store to an Invalid line raises bus_req with bus_excl=1 (invalidate all copies). After bus_ack the line becomes Owned with its dirty flag set.
- R4: A store to a Shared line raises bus_req with bus_excl=1. After bus_ack the line becomes Owned and dirty.
- R5: Loads and stores to an Owned line, and loads to a Shared line, assert lreq_done in the same cycle with no bus_req. A store hit on an Owned line leaves it dirty.
- R6: A snoop invalidation (snp_dgrade=0) to a Shared line makes it Invalid. snp_ack is asserted in the same cycle and there is no writeback.
- R7: A snoop invalidation to a dirty Owned line raises wb_req with the index on wb_line. snp_ack is withheld until wb_ack, and the line then becomes Invalid.
- R8: A snoop downgrade (snp_dgrade=1) to a dirty Owned line writes back first and leaves the line Shared. A downgrade to a Shared or Invalid line is acknowledged in the same cycle and changes nothing.
- R9: Leaving the Owned state or completing a writeback clears the dirty flag. Storing again after re-acquiring ownership sets it again.
- R10: A snoop is served before any local access. No lreq_done is asserted while snp_valid is high or a snoop writeback is outstanding. A snoop that arrives in the same cycle as bus_ack acts on the line's old state, and the local commit follows.
- R11: Once raised, bus_req holds with stable bus_line and bus_excl until bus_ack. wb_req likewise holds with a stable wb_line until wb_ack.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lreq_valid | input | 1 | Local access pending; held until lreq_done |
| lreq_store | input | 1 | 1 = store, 0 = load |
| lreq_line | input | IDXW | Line index of the local access |
| lreq_done | output | 1 | Local access may proceed (one-cycle pulse) |
| bus_req | output | 1 | Bus transaction request |
| bus_excl | output | 1 | 1 = invalidate all copies, 0 = invalidate owner only |
| bus_line | output | IDXW | Line index of the bus transaction |
| bus_ack | input | 1 | Bus granted and completed the transaction |
| snp_valid | input | 1 | Incoming snoop pending; held until snp_ack |
| snp_dgrade | input | 1 | 1 = downgrade, 0 = invalidation |
| snp_line | input | IDXW | Line index of the snoop |
| snp_ack | output | 1 | Snoop served |
| wb_req | output | 1 | Writeback request for dirty data |
| wb_line | output | IDXW | Line index being written back |
| wb_ack | input | 1 | Writeback completed |

## Verification
The hardest case to reach from the ports is a snoop that lands on the very line whose bus transaction is being acknowledged in the same cycle. The stimulus raises bus_ack and snp_valid together, so the snoop demotes the old Shared copy and the store commit then installs Owned. A follow-up invalidation must then demand a writeback. A second hard case is a load that hits while a dirty line's writeback is outstanding. The bench presents both at once and holds wb_ack back, so the hit must stay stalled until the snoop is acknowledged. Line states are never read directly. Each one is inferred from whether the next access misses, which bus kind it raises, and whether the next snoop writes back.

// File: rtl/coh_pkg.sv
// Shared types for the line coherence controller.
// Assumes: three states; the dirty flag only has meaning while Owned.
package coh_pkg;
    typedef enum logic [1:0] {
        LS_INV = 2'd0,
        LS_SHR = 2'd1,
        LS_OWN = 2'd2
    } line_st_e;

    typedef struct packed {
        line_st_e st;
        logic     dirty;
    } line_rec_t;

    localparam line_rec_t REC_RESET = '{st: LS_INV, dirty: 1'b0};
endpackage

// File: rtl/coh_line_bank.sv
// Per-line state and dirty storage with two read ports and two write ports.
// Assumes: the snoop write port wins when both ports target the same line;
// the controllers are arranged so that both never write in one cycle.
module coh_line_bank
    import coh_pkg::*;
#(
    parameter int NLINES = 8,
    localparam int IDXW = (NLINES > 1) ? $clog2(NLINES) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [IDXW-1:0] rd_a_idx,
    output line_rec_t       rd_a,
    input  logic [IDXW-1:0] rd_b_idx,
    output line_rec_t       rd_b,
    input  logic            s_we,
    input  logic [IDXW-1:0] s_idx,
    input  line_rec_t       s_rec,
    input  logic            l_we,
    input  logic [IDXW-1:0] l_idx,
    input  line_rec_t       l_rec
);
    line_rec_t recs [NLINES];

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        // Holds one line's record; snoop updates take priority.
        always_ff @(posedge clk) begin
            if (!rst_n)
                recs[g] <= REC_RESET;
            else if (s_we && s_idx == IDXW'(g))
                recs[g] <= s_rec;
            else if (l_we && l_idx == IDXW'(g))
                recs[g] <= l_rec;
        end
    end

    assign rd_a = recs[rd_a_idx];
    assign rd_b = recs[rd_b_idx];
endmodule

// File: rtl/coh_local_ctrl.sv
// Local access sequencer: completes hits at once, turns misses and
// upgrades into one bus transaction, commits the new state after the ack.
// Assumes: lreq_* held until lreq_done; bus_ack is a one-cycle pulse;
// no commit while a snoop is busy.
module coh_local_ctrl
    import coh_pkg::*;
#(
    parameter int NLINES = 8,
    localparam int IDXW = (NLINES > 1) ? $clog2(NLINES) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            lreq_valid,
    input  logic            lreq_store,
    input  logic [IDXW-1:0] lreq_line,
    input  line_rec_t       cur,
    input  logic            snoop_busy,
    input  logic            bus_ack,
    output logic            lreq_done,
    output logic            bus_req,
    output logic            bus_excl,
    output logic [IDXW-1:0] bus_line,
    output logic            we,
    output logic [IDXW-1:0] widx,
    output line_rec_t       wrec
);
    typedef enum logic [1:0] {L_IDLE, L_BUS, L_COMMIT} lst_e;

    lst_e            st_q;
    logic [IDXW-1:0] line_q;
    logic            excl_q;
    logic            hit;

    // Hit when Owned, or when a load finds the line Shared.
    always_comb begin
        hit = (cur.st == LS_OWN) || (cur.st == LS_SHR && !lreq_store);
    end

    // Sequencer state and the latched transaction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= L_IDLE;
            line_q <= '0;
            excl_q <= 1'b0;
        end else begin
            case (st_q)
                L_IDLE: if (lreq_valid && !snoop_busy && !hit) begin
                    st_q   <= L_BUS;
                    line_q <= lreq_line;
                    excl_q <= lreq_store;
                end
                L_BUS:    if (bus_ack) st_q <= L_COMMIT;
                L_COMMIT: if (!snoop_busy) st_q <= L_IDLE;
                default:  st_q <= L_IDLE;
            endcase
        end
    end

    // Completion, bus request and state-commit outputs.
    always_comb begin
        lreq_done = 1'b0;
        we        = 1'b0;
        widx      = lreq_line;
        wrec      = cur;
        bus_req   = (st_q == L_BUS);
        bus_excl  = excl_q;
        bus_line  = line_q;
        case (st_q)
            L_IDLE: if (lreq_valid && !snoop_busy && hit) begin
                lreq_done  = 1'b1;
                we         = 1'b1;
                wrec.dirty = cur.dirty | lreq_store;
            end
            L_COMMIT: if (!snoop_busy) begin
                lreq_done = 1'b1;
                we        = 1'b1;
                widx      = line_q;
                wrec      = excl_q ? line_rec_t'{st: LS_OWN, dirty: 1'b1}
                                   : line_rec_t'{st: LS_SHR, dirty: 1'b0};
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/coh_snoop_ctrl.sv
// Snoop server: applies invalidations and downgrades, inserting a
// writeback first when the line is Owned and dirty.
// Assumes: snp_* held until snp_ack; wb_ack is a one-cycle pulse.
module coh_snoop_ctrl
    import coh_pkg::*;
#(
    parameter int NLINES = 8,
    localparam int IDXW = (NLINES > 1) ? $clog2(NLINES) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            snp_valid,
    input  logic            snp_dgrade,
    input  logic [IDXW-1:0] snp_line,
    input  line_rec_t       cur,
    input  logic            wb_ack,
    output logic            snp_ack,
    output logic            wb_req,
    output logic [IDXW-1:0] wb_line,
    output logic            busy,
    output logic            we,
    output logic [IDXW-1:0] widx,
    output line_rec_t       wrec
);
    typedef enum logic {S_IDLE, S_WB} sst_e;

    sst_e            st_q;
    logic [IDXW-1:0] line_q;
    logic            dg_q;
    logic            need_wb;

    // A writeback is needed only for modified, owned data.
    always_comb begin
        need_wb = (cur.st == LS_OWN) && cur.dirty;
    end

    // Server state and the latched snoop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= S_IDLE;
            line_q <= '0;
            dg_q   <= 1'b0;
        end else begin
            case (st_q)
                S_IDLE: if (snp_valid && need_wb) begin
                    st_q   <= S_WB;
                    line_q <= snp_line;
                    dg_q   <= snp_dgrade;
                end
                S_WB:    if (wb_ack) st_q <= S_IDLE;
                default: st_q <= S_IDLE;
            endcase
        end
    end

    // Acknowledge, writeback request and next-state outputs.
    always_comb begin
        snp_ack = 1'b0;
        we      = 1'b0;
        widx    = snp_line;
        wrec    = cur;
        wb_req  = (st_q == S_WB);
        wb_line = line_q;
        busy    = snp_valid || (st_q != S_IDLE);
        case (st_q)
            S_IDLE: if (snp_valid && !need_wb) begin
                snp_ack = 1'b1;
                we      = 1'b1;
                if (!snp_dgrade)
                    wrec = REC_RESET;
                else if (cur.st == LS_OWN)
                    wrec = '{st: LS_SHR, dirty: 1'b0};
            end
            S_WB: if (wb_ack) begin
                snp_ack = 1'b1;
                we      = 1'b1;
                widx    = line_q;
                wrec    = dg_q ? line_rec_t'{st: LS_SHR, dirty: 1'b0} : REC_RESET;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/coh_line_ctrl.sv
// Top: bank of per-line coherence records with a local access sequencer
// and a snoop server. Port A of the bank follows the local request, port B
// follows the snoop. Assumes the handshakes described in the brief.
module coh_line_ctrl
    import coh_pkg::*;
#(
    parameter int NLINES = 8,
    localparam int IDXW = (NLINES > 1) ? $clog2(NLINES) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            lreq_valid,
    input  logic            lreq_store,
    input  logic [IDXW-1:0] lreq_line,
    output logic            lreq_done,
    output logic            bus_req,
    output logic            bus_excl,
    output logic [IDXW-1:0] bus_line,
    input  logic            bus_ack,
    input  logic            snp_valid,
    input  logic            snp_dgrade,
    input  logic [IDXW-1:0] snp_line,
    output logic            snp_ack,
    output logic            wb_req,
    output logic [IDXW-1:0] wb_line,
    input  logic            wb_ack
);
    line_rec_t       rec_l, rec_s, wrec_l, wrec_s;
    logic            we_l, we_s, snoop_busy;
    logic [IDXW-1:0] widx_l, widx_s;

    coh_line_bank #(.NLINES(NLINES)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(lreq_line), .rd_a(rec_l),
        .rd_b_idx(snp_line), .rd_b(rec_s),
        .s_we(we_s), .s_idx(widx_s), .s_rec(wrec_s),
        .l_we(we_l), .l_idx(widx_l), .l_rec(wrec_l)
    );

    coh_local_ctrl #(.NLINES(NLINES)) u_local (
        .clk(clk), .rst_n(rst_n),
        .lreq_valid(lreq_valid), .lreq_store(lreq_store), .lreq_line(lreq_line),
        .cur(rec_l), .snoop_busy(snoop_busy), .bus_ack(bus_ack),
        .lreq_done(lreq_done), .bus_req(bus_req), .bus_excl(bus_excl),
        .bus_line(bus_line), .we(we_l), .widx(widx_l), .wrec(wrec_l)
    );

    coh_snoop_ctrl #(.NLINES(NLINES)) u_snoop (
        .clk(clk), .rst_n(rst_n),
        .snp_valid(snp_valid), .snp_dgrade(snp_dgrade), .snp_line(snp_line),
        .cur(rec_s), .wb_ack(wb_ack), .snp_ack(snp_ack), .wb_req(wb_req),
        .wb_line(wb_line), .busy(snoop_busy),
        .we(we_s), .widx(widx_s), .wrec(wrec_s)
    );
endmodule

// File: rtl/coh_line_ctrl_chk.sv
// Port-level protocol checks for coh_line_ctrl, attached by bind.
module coh_line_ctrl_chk #(
    parameter int IDXW = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            lreq_valid,
    input logic            lreq_store,
    input logic            lreq_done,
    input logic            bus_req,
    input logic            bus_excl,
    input logic [IDXW-1:0] bus_line,
    input logic            bus_ack,
    input logic            snp_valid,
    input logic            snp_ack,
    input logic            wb_req,
    input logic [IDXW-1:0] wb_line,
    input logic            wb_ack
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> !bus_req && !wb_req);
    // R11
    bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack |=> bus_req && $stable(bus_line) && $stable(bus_excl));
    // R11
    wb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req && !wb_ack |=> wb_req && $stable(wb_line));
    // R10
    local_yield_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lreq_done |-> !snp_valid && !wb_req);
    // R5
    done_no_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lreq_done |-> !bus_req);
    // R7
    ack_after_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req && !wb_ack |-> !snp_ack);
    // R3
    bus_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> $past(lreq_valid) && bus_excl == $past(lreq_store));
    // R6
    ack_needs_snoop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snp_ack |-> snp_valid);
endmodule

bind coh_line_ctrl coh_line_ctrl_chk #(.IDXW(IDXW)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .lreq_valid(lreq_valid), .lreq_store(lreq_store), .lreq_done(lreq_done),
    .bus_req(bus_req), .bus_excl(bus_excl), .bus_line(bus_line), .bus_ack(bus_ack),
    .snp_valid(snp_valid), .snp_ack(snp_ack),
    .wb_req(wb_req), .wb_line(wb_line), .wb_ack(wb_ack)
);

// File: tb/tb_coh_line_ctrl.sv
module tb_coh_line_ctrl;
    localparam int NL = 8;
    localparam int IW = 3;

    typedef enum int {EV_BUS, EV_WB, EV_SACK, EV_LDONE} ev_e;
    typedef struct { ev_e kind; int line; int excl; string req; } ev_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lreq_valid = 1'b0, lreq_store = 1'b0;
    logic [IW-1:0] lreq_line = '0;
    logic lreq_done, bus_req, bus_excl, snp_ack, wb_req;
    logic [IW-1:0] bus_line, wb_line;
    logic bus_ack = 1'b0, snp_valid = 1'b0, snp_dgrade = 1'b0, wb_ack = 1'b0;
    logic [IW-1:0] snp_line = '0;

    int n_cmp = 0, n_bad = 0;
    bit finished = 1'b0;
    ev_t exp_q[$];
    logic bus_prev = 1'b0, wb_prev = 1'b0;

    always #10 clk = ~clk;

    coh_line_ctrl #(.NLINES(NL)) dut (
        .clk(clk), .rst_n(rst_n),
        .lreq_valid(lreq_valid), .lreq_store(lreq_store), .lreq_line(lreq_line),
        .lreq_done(lreq_done), .bus_req(bus_req), .bus_excl(bus_excl),
        .bus_line(bus_line), .bus_ack(bus_ack),
        .snp_valid(snp_valid), .snp_dgrade(snp_dgrade), .snp_line(snp_line),
        .snp_ack(snp_ack), .wb_req(wb_req), .wb_line(wb_line), .wb_ack(wb_ack)
    );

    task automatic check(input int act, input int exp, input string what);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic push(input ev_e k, input int line, input int excl, input string req);
        ev_t e;
        e.kind = k; e.line = line; e.excl = excl; e.req = req;
        exp_q.push_back(e);
    endtask

    // Monitor: pops the expected event for each observed one.
    task automatic observe(input ev_e k, input int line, input int excl);
        ev_t e;
        n_cmp++;
        if (exp_q.size() == 0) begin
            n_bad++;
            $display("FAIL unexpected event: actual kind %0d line %0d expected none", k, line);
            return;
        end
        e = exp_q.pop_front();
        if (e.kind != k || e.line != line || e.excl != excl) begin
            n_bad++;
            $display("FAIL %s: actual kind %0d line %0d excl %0d expected kind %0d line %0d excl %0d",
                     e.req, k, line, excl, e.kind, e.line, e.excl);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (bus_req && !bus_prev) observe(EV_BUS, int'(bus_line), int'(bus_excl));
            if (wb_req && !wb_prev)   observe(EV_WB, int'(wb_line), 0);
            if (snp_ack)              observe(EV_SACK, int'(snp_line), 0);
            if (lreq_done)            observe(EV_LDONE, int'(lreq_line), 0);
        end
        bus_prev = bus_req;
        wb_prev  = wb_req;
    end

    // Driver: one local access; a miss waits ack_dly cycles before bus_ack.
    task automatic do_local(input int line, input bit st, input bit miss,
                            input int ack_dly, input string req);
        if (miss) push(EV_BUS, line, int'(st), req);
        push(EV_LDONE, line, 0, req);
        @(posedge clk); #1;
        lreq_valid = 1'b1; lreq_store = st; lreq_line = IW'(line);
        if (!miss) begin
            @(negedge clk);
            check(int'(lreq_done), 1, {req, " same-cycle completion"});
        end else begin
            do @(negedge clk); while (!bus_req);
            for (int i = 0; i < ack_dly; i++) begin
                @(negedge clk);
                check(int'(bus_req && bus_line == IW'(line)), 1, "R11 bus_req held");
            end
            @(posedge clk); #1 bus_ack = 1'b1;
            @(posedge clk); #1 bus_ack = 1'b0;
            @(negedge clk);
            while (!lreq_done) @(negedge clk);
        end
        @(posedge clk); #1 lreq_valid = 1'b0;
    endtask

    // Driver: one snoop; a writeback is acked after wb_dly cycles.
    task automatic do_snoop(input int line, input bit dg, input bit wb,
                            input int wb_dly, input string req);
        if (wb) push(EV_WB, line, 0, req);
        push(EV_SACK, line, 0, req);
        @(posedge clk); #1;
        snp_valid = 1'b1; snp_dgrade = dg; snp_line = IW'(line);
        if (wb) begin
            do @(negedge clk); while (!wb_req);
            for (int i = 0; i < wb_dly; i++) begin
                @(negedge clk);
                check(int'(wb_req && !snp_ack), 1, "R7 R11 wb_req held, ack withheld");
            end
            @(posedge clk); #1 wb_ack = 1'b1;
            @(negedge clk);
            while (!snp_ack) @(negedge clk);
        end else begin
            @(negedge clk);
            check(int'(snp_ack), 1, {req, " same-cycle snoop ack"});
        end
        @(posedge clk); #1 snp_valid = 1'b0; wb_ack = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(int'({bus_req, wb_req, lreq_done, snp_ack}), 0, "R1 outputs quiet in reset");
        @(posedge clk); #1 rst_n = 1'b1;

        // R1 R2: lines start Invalid; load miss installs Shared
        do_local(0, 1'b0, 1'b1, 0, "R1 R2 load miss");
        do_local(0, 1'b0, 1'b0, 0, "R5 load hit Shared");
        // R4: upgrade Shared to Owned
        do_local(0, 1'b1, 1'b1, 2, "R4 store to Shared");
        do_local(0, 1'b0, 1'b0, 0, "R5 load hit Owned");
        do_local(0, 1'b1, 1'b0, 0, "R5 store hit Owned");
        // R3: store miss to Owned dirty, proven by writeback on invalidation
        do_local(1, 1'b1, 1'b1, 0, "R3 store miss");
        do_snoop(1, 1'b0, 1'b1, 2, "R7 invalidate dirty owner");
        do_local(1, 1'b0, 1'b1, 0, "R7 line now Invalid");
        // R8 R9: downgrade writes back, then line clean and Shared
        do_snoop(0, 1'b1, 1'b1, 1, "R8 downgrade dirty owner");
        do_local(0, 1'b0, 1'b0, 0, "R8 line Shared after downgrade");
        do_snoop(0, 1'b0, 1'b0, 0, "R9 dirty cleared, no writeback");
        do_local(0, 1'b0, 1'b1, 0, "R6 line Invalid after snoop");
        // R6: Shared line invalidated without writeback
        do_snoop(1, 1'b0, 1'b0, 0, "R6 invalidate Shared");
        do_local(1, 1'b0, 1'b1, 0, "R6 reload after invalidation");
        // R8: downgrade of Shared and Invalid lines has no effect
        do_snoop(1, 1'b1, 1'b0, 0, "R8 downgrade Shared");
        do_local(1, 1'b0, 1'b0, 0, "R8 Shared kept");
        do_snoop(6, 1'b1, 1'b0, 0, "R8 downgrade Invalid");
        do_local(6, 1'b0, 1'b1, 0, "R8 Invalid kept");
        // R9: re-acquired ownership sets dirty again
        do_local(0, 1'b1, 1'b1, 0, "R4 store upgrade");
        do_snoop(0, 1'b1, 1'b1, 0, "R9 downgrade writes back");
        do_local(0, 1'b1, 1'b1, 0, "R4 store upgrade again");
        do_snoop(0, 1'b1, 1'b1, 0, "R9 dirty set again");

        // R10: hit held back behind a writeback
        do_local(2, 1'b1, 1'b1, 0, "R3 store miss line 2");
        do_local(7, 1'b0, 1'b1, 0, "R2 load miss line 7");
        push(EV_WB, 2, 0, "R10 snoop first");
        push(EV_SACK, 2, 0, "R10 snoop first");
        push(EV_LDONE, 7, 0, "R10 local after snoop");
        @(posedge clk); #1;
        snp_valid = 1'b1; snp_dgrade = 1'b0; snp_line = 3'd2;
        lreq_valid = 1'b1; lreq_store = 1'b0; lreq_line = 3'd7;
        @(negedge clk);
        check(int'(lreq_done), 0, "R10 hit stalled by snoop");
        do @(negedge clk); while (!wb_req);
        @(negedge clk);
        check(int'(lreq_done), 0, "R10 hit stalled during writeback");
        @(posedge clk); #1 wb_ack = 1'b1;
        @(negedge clk);
        check(int'(snp_ack && !lreq_done), 1, "R10 snoop acked before hit");
        @(posedge clk); #1 wb_ack = 1'b0; snp_valid = 1'b0;
        @(negedge clk);
        check(int'(lreq_done), 1, "R10 hit completes after snoop");
        @(posedge clk); #1 lreq_valid = 1'b0;

        // R10: snoop arrives with bus_ack on the same line
        do_local(5, 1'b0, 1'b1, 0, "R2 load miss line 5");
        push(EV_BUS, 5, 1, "R10 upgrade");
        push(EV_SACK, 5, 0, "R10 snoop on old state");
        push(EV_LDONE, 5, 0, "R10 commit after snoop");
        @(posedge clk); #1;
        lreq_valid = 1'b1; lreq_store = 1'b1; lreq_line = 3'd5;
        do @(negedge clk); while (!bus_req);
        @(posedge clk); #1;
        bus_ack = 1'b1; snp_valid = 1'b1; snp_dgrade = 1'b0; snp_line = 3'd5;
        @(negedge clk);
        check(int'(snp_ack && !lreq_done && !wb_req), 1, "R10 snoop served on Shared copy");
        @(posedge clk); #1 bus_ack = 1'b0; snp_valid = 1'b0;
        @(negedge clk);
        check(int'(lreq_done), 1, "R10 store commits after snoop");
        @(posedge clk); #1 lreq_valid = 1'b0;
        do_snoop(5, 1'b0, 1'b1, 0, "R10 R3 line 5 Owned dirty");

        repeat (3) @(posedge clk);
        check(exp_q.size(), 0, "all expected events seen");
        finished = 1'b1;
        summary();
        $finish;
    end
endmodule